// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 14-bit virtual address into a 16-bit physical address. It uses a four-entry segment table. Each entry holds a physical base, a segment size, a write-permission bit and a valid bit. The two upper address bits pick the entry and the twelve lower bits are the offset within the segment.

The translation path is purely combinational. It checks the offset against the segment size and checks the access type against the write permission. When both checks pass, it adds the offset to the base. When an access is refused, the block raises a trap with a cause code and drives a zero address. While the kernel-mode input is high, the address goes through unchanged and nothing traps.

The table is loaded through a write port that only takes effect in kernel mode. A write attempted in user mode leaves the table untouched and raises a privilege-fault flag for one cycle.

Top module: `seg_xlate`

## Requirements
- R1: In user mode, the segment is vaddr[13:12] and the offset is vaddr[11:0]. An access that passes all checks gives paddr = (base + offset) mod 2^16, with trap low and cause 0.
- R2: In user mode, a valid segment with offset >= size raises trap with cause 1 (bound), and paddr is 0. Size is a 13-bit count, so size 0 refuses every offset and size 0x1000 allows all offsets.
- R3: In user mode, a store (store_i=1) to an in-range offset of a valid segment whose write bit is 0 raises trap with cause 2 (protection). A load or fetch (store_i=0) to the same segment does not trap.
- R4: A segment whose write bit is 1 accepts in-range stores without a trap.
- R5: In user mode, any access through an entry whose valid bit is 0 traps with cause 3 (invalid). The checks have a fixed priority: invalid, then bound, then protection.
- R6: While kern_i is 1, paddr equals the zero-extended vaddr, trap is 0 and cause is 0, whatever the table holds and whatever store_i is.
- R7: A write with wr_en_i=1 and kern_i=1 at a rising clock edge replaces all four fields of entry wr_sel_i. The new values are used for translation from that edge onward.
- R8: A write with wr_en_i=1 and kern_i=0 leaves the table unchanged. It sets priv_fault_o to 1 for exactly the cycle after that edge.
- R9: Reset (rst_n low, asynchronous) makes every entry invalid and clears priv_fault_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kern_i | input | 1 | Kernel mode: enables table writes and bypasses translation |
| wr_en_i | input | 1 | Table write request |
| wr_sel_i | input | 2 | Entry to write |
| wr_base_i | input | 16 | New physical base |
| wr_size_i | input | 13 | New segment size in bytes |
| wr_rw_i | input | 1 | New write permission (1 = stores allowed) |
| wr_valid_i | input | 1 | New valid bit |
| vaddr_i | input | 14 | Virtual address to translate |
| store_i | input | 1 | Access is a store (0 = load or fetch) |
| paddr_o | output | 16 | Physical address, 0 on a trap |
| trap_o | output | 1 | Access refused |
| trap_cause_o | output | 2 | 0 none, 1 bound, 2 protection, 3 invalid |
| priv_fault_o | output | 1 | User-mode table write was dropped (one cycle) |

## Verification
The assertions assume that the translation inputs only change away from the rising edge. They also assume that wr_sel_i always names an existing entry. The second holds by width in the default configuration.

The stimulus drives table writes at falling edges and holds them for one full cycle. It then sweeps every virtual address with both store values while no write is pending. This way, each combinational result is taken from a settled table.

// File: rtl/seg_pkg.sv
package seg_pkg;
    // Reason an access was refused; value 0 means the access was granted.
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_BOUND = 2'd1,
        CAUSE_PROT  = 2'd2,
        CAUSE_INVAL = 2'd3
    } cause_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int N_SEG = 4,
    parameter int PA_W  = 16,
    parameter int SZ_W  = 13,
    parameter int IDX_W = $clog2(N_SEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kern_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_sel_i,
    input  logic [PA_W-1:0]  wr_base_i,
    input  logic [SZ_W-1:0]  wr_size_i,
    input  logic             wr_rw_i,
    input  logic             wr_valid_i,
    input  logic [IDX_W-1:0] rd_sel_i,
    output logic             rd_valid_o,
    output logic             rd_rw_o,
    output logic [PA_W-1:0]  rd_base_o,
    output logic [SZ_W-1:0]  rd_size_o,
    output logic             priv_fault_o
);
    typedef struct packed {
        logic [N_SEG-1:0]            valid;
        logic [N_SEG-1:0]            rw;
        logic [N_SEG-1:0][PA_W-1:0]  base;
        logic [N_SEG-1:0][SZ_W-1:0]  size;
        logic                        priv;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.priv = 1'b0;
        if (wr_en_i) begin
            if (kern_i) begin
                st_d.valid[wr_sel_i] = wr_valid_i;
                st_d.rw[wr_sel_i]    = wr_rw_i;
                st_d.base[wr_sel_i]  = wr_base_i;
                st_d.size[wr_sel_i]  = wr_size_i;
            end else begin
                st_d.priv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid_o   = st_q.valid[rd_sel_i];
    assign rd_rw_o      = st_q.rw[rd_sel_i];
    assign rd_base_o    = st_q.base[rd_sel_i];
    assign rd_size_o    = st_q.size[rd_sel_i];
    assign priv_fault_o = st_q.priv;

    // R7: a privileged write is visible in the table after the edge
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && kern_i) |=>
            (st_q.base[$past(wr_sel_i)] == $past(wr_base_i)) &&
            (st_q.size[$past(wr_sel_i)] == $past(wr_size_i)) &&
            (st_q.rw[$past(wr_sel_i)] == $past(wr_rw_i)) &&
            (st_q.valid[$past(wr_sel_i)] == $past(wr_valid_i)));

    // R8: an unprivileged write changes no table field
    a_r8_user_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !kern_i) |=>
            $stable(st_q.valid) && $stable(st_q.rw) &&
            $stable(st_q.base) && $stable(st_q.size));

    // R8: the fault flag follows a dropped write and nothing else
    a_r8_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !kern_i) |=> priv_fault_o);
    a_r8_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && !kern_i) |=> !priv_fault_o);
endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_pkg::*;
#(
    parameter int VA_W  = 14,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16,
    parameter int SZ_W  = OFF_W + 1
) (
    input  logic [VA_W-1:0] vaddr_i,
    input  logic            kern_i,
    input  logic            store_i,
    input  logic            valid_i,
    input  logic            rw_i,
    input  logic [PA_W-1:0] base_i,
    input  logic [SZ_W-1:0] size_i,
    output logic [PA_W-1:0] paddr_o,
    output logic            trap_o,
    output cause_e          cause_o
);
    logic [OFF_W-1:0] off;
    logic [PA_W-1:0]  off_ext;
    logic [PA_W-1:0]  va_ext;

    always_comb begin
        off     = vaddr_i[OFF_W-1:0];
        off_ext = {{(PA_W-OFF_W){1'b0}}, off};
        va_ext  = {{(PA_W-VA_W){1'b0}}, vaddr_i};
        cause_o = CAUSE_NONE;
        if (!kern_i) begin
            if (!valid_i)                               cause_o = CAUSE_INVAL;
            else if ({{(SZ_W-OFF_W){1'b0}}, off} >= size_i) cause_o = CAUSE_BOUND;
            else if (store_i && !rw_i)                  cause_o = CAUSE_PROT;
        end
        trap_o = (cause_o != CAUSE_NONE);
        if (kern_i)      paddr_o = va_ext;
        else if (trap_o) paddr_o = '0;
        else             paddr_o = base_i + off_ext;
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int VA_W  = 14,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16,
    parameter int SEG_W = VA_W - OFF_W,
    parameter int SZ_W  = OFF_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kern_i,
    input  logic             wr_en_i,
    input  logic [SEG_W-1:0] wr_sel_i,
    input  logic [PA_W-1:0]  wr_base_i,
    input  logic [SZ_W-1:0]  wr_size_i,
    input  logic             wr_rw_i,
    input  logic             wr_valid_i,
    input  logic [VA_W-1:0]  vaddr_i,
    input  logic             store_i,
    output logic [PA_W-1:0]  paddr_o,
    output logic             trap_o,
    output logic [1:0]       trap_cause_o,
    output logic             priv_fault_o
);
    localparam int N_SEG = 1 << SEG_W;

    logic             ent_valid, ent_rw;
    logic [PA_W-1:0]  ent_base;
    logic [SZ_W-1:0]  ent_size;
    cause_e           cause;

    seg_table #(.N_SEG(N_SEG), .PA_W(PA_W), .SZ_W(SZ_W), .IDX_W(SEG_W)) u_table (
        .clk(clk), .rst_n(rst_n), .kern_i(kern_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_base_i(wr_base_i),
        .wr_size_i(wr_size_i), .wr_rw_i(wr_rw_i), .wr_valid_i(wr_valid_i),
        .rd_sel_i(vaddr_i[VA_W-1:OFF_W]),
        .rd_valid_o(ent_valid), .rd_rw_o(ent_rw), .rd_base_o(ent_base),
        .rd_size_o(ent_size), .priv_fault_o(priv_fault_o)
    );

    seg_check #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .SZ_W(SZ_W)) u_check (
        .vaddr_i(vaddr_i), .kern_i(kern_i), .store_i(store_i),
        .valid_i(ent_valid), .rw_i(ent_rw), .base_i(ent_base), .size_i(ent_size),
        .paddr_o(paddr_o), .trap_o(trap_o), .cause_o(cause)
    );

    assign trap_cause_o = cause;

    // R6: kernel accesses bypass the table
    a_r6_kern_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        kern_i |-> (paddr_o == {{(PA_W-VA_W){1'b0}}, vaddr_i}) && !trap_o);

    // R5: an invalid entry always reports the invalid cause
    a_r5_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (!kern_i && !ent_valid) |-> trap_o && (trap_cause_o == 2'd3));

    // R2: out-of-range offset in a valid segment reports a bound fault
    a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (!kern_i && ent_valid && ({1'b0, vaddr_i[OFF_W-1:0]} >= ent_size))
            |-> trap_o && (trap_cause_o == 2'd1) && (paddr_o == '0));

    // R3: in-range store to a read-only segment reports a protection fault
    a_r3_prot: assert property (@(posedge clk) disable iff (!rst_n)
        (!kern_i && ent_valid && ({1'b0, vaddr_i[OFF_W-1:0]} < ent_size)
         && store_i && !ent_rw) |-> trap_o && (trap_cause_o == 2'd2));

    // R1: a granted user access lands at base plus offset
    a_r1_granted_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (!kern_i && !trap_o) |->
            (paddr_o == ent_base + {{(PA_W-OFF_W){1'b0}}, vaddr_i[OFF_W-1:0]})
            && (trap_cause_o == 2'd0));
endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kern_i = 1'b0, wr_en_i = 1'b0, wr_rw_i = 1'b0, wr_valid_i = 1'b0;
    logic [1:0]  wr_sel_i = '0;
    logic [15:0] wr_base_i = '0;
    logic [12:0] wr_size_i = '0;
    logic [13:0] vaddr_i = '0;
    logic        store_i = 1'b0;
    logic [15:0] paddr_o;
    logic        trap_o, priv_fault_o;
    logic [1:0]  trap_cause_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate uut (
        .clk(clk), .rst_n(rst_n), .kern_i(kern_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_base_i(wr_base_i), .wr_size_i(wr_size_i),
        .wr_rw_i(wr_rw_i), .wr_valid_i(wr_valid_i), .vaddr_i(vaddr_i),
        .store_i(store_i), .paddr_o(paddr_o), .trap_o(trap_o),
        .trap_cause_o(trap_cause_o), .priv_fault_o(priv_fault_o)
    );

    int n_vec = 0, n_bad = 0;
    logic [15:0] m_base [4];
    logic [12:0] m_size [4];
    logic        m_rw   [4];
    logic        m_val  [4];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Translate one address and compare {paddr, trap, cause} with the model
    task automatic probe(string tag, logic [13:0] va, logic st, logic k);
        logic [1:0]  sg;
        logic [11:0] of;
        logic [15:0] e_pa;
        logic        e_tr;
        logic [1:0]  e_ca;
        string       req;
        vaddr_i = va; store_i = st; kern_i = k;
        #1;
        sg = va[13:12]; of = va[11:0];
        e_pa = 16'h0; e_tr = 1'b1; e_ca = 2'd0;
        if (k) begin
            e_pa = {2'b00, va}; e_tr = 1'b0; req = "R6";
        end else if (!m_val[sg]) begin
            e_ca = 2'd3; req = "R5";
        end else if ({1'b0, of} >= m_size[sg]) begin
            e_ca = 2'd1; req = "R2";
        end else if (st && !m_rw[sg]) begin
            e_ca = 2'd2; req = "R3";
        end else begin
            e_pa = m_base[sg] + {4'h0, of}; e_tr = 1'b0;
            req = st ? "R4" : "R1";
        end
        if (tag != "") req = tag;
        check(req, {13'h0, paddr_o, trap_o, trap_cause_o}, {13'h0, e_pa, e_tr, e_ca});
    endtask

    task automatic write_entry(int sel, logic [15:0] b, logic [12:0] s,
                               logic rw, logic val, logic k);
        @(negedge clk);
        kern_i = k; wr_en_i = 1'b1; wr_sel_i = sel[1:0];
        wr_base_i = b; wr_size_i = s; wr_rw_i = rw; wr_valid_i = val;
        @(negedge clk);
        wr_en_i = 1'b0;
        if (k) begin
            m_base[sel] = b; m_size[sel] = s; m_rw[sel] = rw; m_val[sel] = val;
        end
        check("R8 flag", {31'h0, priv_fault_o}, {31'h0, !k});
        @(negedge clk);
        check("R8 one cycle", {31'h0, priv_fault_o}, 32'h0);
    endtask

    task automatic sweep_user();
        for (int v = 0; v < 16384; v++) begin
            probe("", v[13:0], 1'b0, 1'b0);
            probe("", v[13:0], 1'b1, 1'b0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_base[i] = '0; m_size[i] = '0; m_rw[i] = 1'b0; m_val[i] = 1'b0;
        end
        // R9: reset state, every segment invalid and no fault flag
        @(negedge clk); @(negedge clk);
        for (int s = 0; s < 4; s++) probe("R9", {s[1:0], 12'h010}, 1'b0, 1'b0);
        check("R9 flag", {31'h0, priv_fault_o}, 32'h0);
        rst_n = 1'b1;

        // Configuration A: read-only, read-write, invalid, full-size segments
        write_entry(0, 16'h4000, 13'h0700, 1'b0, 1'b1, 1'b1);
        probe("R7", 14'h06FF, 1'b0, 1'b0);
        probe("R7", 14'h0700, 1'b0, 1'b0);
        write_entry(1, 16'h0000, 13'h0500, 1'b1, 1'b1, 1'b1);
        write_entry(2, 16'h9000, 13'h0800, 1'b1, 1'b0, 1'b1);
        write_entry(3, 16'h2000, 13'h1000, 1'b1, 1'b1, 1'b1);
        sweep_user();

        // R8: user-mode write to segment 0 must leave it read-only at 0x4000
        write_entry(0, 16'h1111, 13'h1000, 1'b1, 1'b1, 1'b0);
        probe("R8", 14'h0004, 1'b1, 1'b0);
        probe("R8", 14'h0004, 1'b0, 1'b0);
        probe("R8", 14'h0800, 1'b0, 1'b0);

        // R6: kernel bypass across all addresses
        for (int v = 0; v < 16384; v += 3) probe("R6", v[13:0], v[0], 1'b1);

        // Configuration B: wrapping base, zero size, odd size, invalid
        write_entry(0, 16'hF800, 13'h1000, 1'b1, 1'b1, 1'b1);
        write_entry(1, 16'h3000, 13'h0000, 1'b0, 1'b1, 1'b1);
        write_entry(2, 16'h1234, 13'h0FFF, 1'b0, 1'b1, 1'b1);
        write_entry(3, 16'h2000, 13'h1000, 1'b1, 1'b0, 1'b1);
        sweep_user();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule